// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns a graphics aperture address into a physical page number. The upper part of the aperture address, taken relative to a programmable base, selects one of 64 on-chip directory slots. Each slot points at a 4 KB table in system memory that holds 1024 32-bit page entries, so one slot spans 4 MB of aperture. Aperture address bits 21:12 pick the entry within that table. The block reads the entry through a single-request memory read port and returns the page number or a fault code.

Software programs the block through one configuration write port. The port selects a directory load register, an aperture base register, a size register and a control register. A four-entry fully associative cache holds recent successful translations. It is cleared when control bit 7 goes from 0 to 1. Only one table walk is in flight at a time.

Top module: `aperture_walker`

## Requirements
- R1: A configuration write with `cfg_sel`=2'b00 loads a directory slot. The slot is `cfg_wdata[5:0]`, the present flag is bit 8 and the table page is bits 31:12. A walk through a present slot issues one read at address {slot page, request bits 21:12, 2'b00}.
- R2: A directory write with bit 8 clear marks that slot absent. A request that lands on an absent slot gets status 2'b01 (translation fault) one cycle after acceptance and issues no memory read.
- R3: The directory index is request bits 31:22 minus base bits 31:22, with 10-bit wraparound. The base is written with `cfg_sel`=2'b01, and bits 21:0 of that write are ignored.
- R4: The size register is written with `cfg_sel`=2'b10. The values 0, 32, 48 and 56 enable 64, 32, 16 and 8 directory slots. An index at or beyond the enabled count gets status 2'b10 (range fault) one cycle after acceptance, and no read is issued.
- R5: A table entry with bit 0 set returns status 2'b00 and `rsp_page` equal to entry bits 31:12. An entry with bit 0 clear returns status 2'b01.
- R6: A cache hit answers one cycle after acceptance with no memory read. A walk answers one cycle after `mem_rsp_valid`.
- R7: The cache holds four translations and replaces them in round-robin order. After five distinct successful walks the first of them is walked again, and the fourth still hits.
- R8: A control write (`cfg_sel`=2'b11) clears the cache only when it sets bit 7 while bit 7 was 0. Writes that leave bit 7 unchanged keep stale cached translations.
- R9: Faulting translations are never cached, so repeating a faulting walk reads memory again.
- R10: `req_ready` is low from the acceptance of a walk until its response. `mem_rd_valid` is a one-cycle pulse.
- R11: After reset `req_ready` is 1 and `rsp_valid` and `mem_rd_valid` are 0. The size is 0 (64 slots), the base is 0, every slot is absent and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 directory, 1 base, 2 size, 3 control |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Aperture address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 translation fault, 2 range fault |
| rsp_page | output | 20 | Physical page number when status is 0 |
| mem_rd_valid | output | 1 | Table-entry read request pulse |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read from memory |

## Verification
A wrong directory slot or a bad index subtraction shows up within the same request as a wrong `mem_rd_addr`, or as a fault where a read was expected. Stale or lost cache state shows only on a later request to the same page, as a one-cycle answer where a two-cycle walk was due, or the reverse. The tests therefore repeat addresses around every flush and eviction and compare both latency and read count. A mis-tracked control bit 7 shows up on the first request after a control write that should or should not have cleared the cache.

// File: rtl/aperture_walker.sv
module aperture_walker #(
  parameter int DIR_SLOTS  = 64,
  parameter int CACHE_WAYS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  output logic [1:0]  rsp_status,
  output logic [19:0] rsp_page,
  output logic        mem_rd_valid,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam int DW = $clog2(DIR_SLOTS);
  localparam int CW = DW + 1;
  localparam int WW = $clog2(CACHE_WAYS);

  logic [DIR_SLOTS-1:0] dir_vld;
  logic [19:0]          dir_page [DIR_SLOTS];
  logic [9:0]           base_hi;
  logic [DW-1:0]        size_sel;
  logic                 ctl_b7;
  logic [CACHE_WAYS-1:0] c_vld;
  logic [19:0]          c_tag  [CACHE_WAYS];
  logic [19:0]          c_page [CACHE_WAYS];
  logic [WW-1:0]        rr;
  logic                 busy;
  logic [19:0]          walk_tag;
  logic                 hit;
  logic [19:0]          hit_page;

  wire [9:0]    dir_idx  = req_addr[31:22] - base_hi;
  wire [CW-1:0] dir_cnt  = CW'(DIR_SLOTS) - CW'(size_sel);
  wire          in_range = {{(10-CW){1'b0}}, dir_cnt} > dir_idx;
  wire [DW-1:0] slot     = dir_idx[DW-1:0];
  wire          accept   = req_valid && !busy;
  wire          flush    = cfg_we && cfg_sel == 2'b11 && cfg_wdata[7] && !ctl_b7;
  wire          fill     = busy && mem_rsp_valid && mem_rsp_data[0];
  wire          unused_bits = ^{cfg_wdata[11:9], cfg_wdata[6], mem_rsp_data[11:1]};

  assign req_ready = !busy;

  always_comb begin
    hit = 1'b0;
    hit_page = '0;
    for (int i = 0; i < CACHE_WAYS; i++)
      if (c_vld[i] && c_tag[i] == req_addr[31:12]) begin
        hit = 1'b1;
        hit_page = c_page[i];
      end
  end

  always_ff @(posedge clk)
    if (cfg_we && cfg_sel == 2'b00)
      dir_page[cfg_wdata[DW-1:0]] <= cfg_wdata[31:12];

  always_ff @(posedge clk)
    if (fill) begin
      c_tag[rr]  <= walk_tag;
      c_page[rr] <= mem_rsp_data[31:12];
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_vld      <= '0;
      base_hi      <= '0;
      size_sel     <= '0;
      ctl_b7       <= 1'b0;
      c_vld        <= '0;
      rr           <= '0;
      busy         <= 1'b0;
      walk_tag     <= '0;
      rsp_valid    <= 1'b0;
      rsp_status   <= 2'b00;
      rsp_page     <= '0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      mem_rd_valid <= 1'b0;
      if (cfg_we)
        case (cfg_sel)
          2'b00: dir_vld[cfg_wdata[DW-1:0]] <= cfg_wdata[8];
          2'b01: base_hi <= cfg_wdata[31:22];
          2'b10: size_sel <= cfg_wdata[DW-1:0];
          default: ctl_b7 <= cfg_wdata[7];
        endcase
      if (accept) begin
        if (!in_range) begin
          rsp_valid  <= 1'b1;
          rsp_status <= 2'b10;
          rsp_page   <= '0;
        end else if (hit) begin
          rsp_valid  <= 1'b1;
          rsp_status <= 2'b00;
          rsp_page   <= hit_page;
        end else if (!dir_vld[slot]) begin
          rsp_valid  <= 1'b1;
          rsp_status <= 2'b01;
          rsp_page   <= '0;
        end else begin
          busy         <= 1'b1;
          mem_rd_valid <= 1'b1;
          mem_rd_addr  <= {dir_page[slot], req_addr[21:12], 2'b00};
          walk_tag     <= req_addr[31:12];
        end
      end
      if (busy && mem_rsp_valid) begin
        busy       <= 1'b0;
        rsp_valid  <= 1'b1;
        rsp_status <= mem_rsp_data[0] ? 2'b00 : 2'b01;
        rsp_page   <= mem_rsp_data[0] ? mem_rsp_data[31:12] : 20'd0;
        if (fill) begin
          c_vld[rr] <= 1'b1;
          rr        <= rr + 1'b1;
        end
      end
      if (flush) c_vld <= '0;
    end
  end
endmodule

// File: rtl/aperture_walker_chk.sv
module aperture_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [1:0] rsp_status,
  input logic       mem_rd_valid,
  input logic       mem_rsp_valid
);
  a_r10_busy_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);
  a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);
  a_r6_accept_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || mem_rd_valid));
  a_r6_walk_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !req_ready) |=> (rsp_valid && req_ready));
  a_r4_range_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'b10) |-> !$past(mem_rsp_valid));
  a_r10_no_read_and_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && mem_rd_valid));
endmodule

bind aperture_walker aperture_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .mem_rd_valid(mem_rd_valid), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/aperture_walker_tb_top.sv
module aperture_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'b00;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [19:0] rsp_page;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  logic [31:0] last_ra = '0;
  logic [19:0] exp_dir [64];
  bit done = 0;

  always #10 clk = ~clk;

  aperture_walker dut_i (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[21:2] + 20'h12345, 11'd0, (a[11:2] % 7) != 0};
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (mem_rd_valid) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(mem_rd_addr);
      last_ra       = mem_rd_addr;
      rd_count++;
    end
  end

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic dir_load(input int s, input logic [19:0] pg, input bit present);
    cfg(2'b00, {pg, 3'b000, present, 2'b00, 6'(s)});
    exp_dir[s] = pg;
  endtask

  task automatic run(input string tag, input logic [31:0] a, input logic [1:0] exp_st,
                     input bit walk, input bit use_pg, input logic [19:0] pg_in);
    int r0;
    int lat;
    logic rdy_mid;
    logic [9:0] idx;
    logic [31:0] exp_ra;
    logic [19:0] exp_pg;
    r0 = rd_count;
    idx = a[31:22] - 10'h380;
    exp_ra = {exp_dir[idx[5:0]], a[21:12], 2'b00};
    exp_pg = use_pg ? pg_in : mem_word(exp_ra) >> 12;
    @(negedge clk);
    chk({tag, " ready before request"}, req_ready == 1'b1, req_ready, 1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    rdy_mid = req_ready;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk({tag, " status"}, rsp_status == exp_st, rsp_status, exp_st);
    chk({tag, " latency"}, lat == (walk ? 2 : 1), lat, walk ? 2 : 1);
    chk({tag, " reads"}, (rd_count - r0) == (walk ? 1 : 0), rd_count - r0, walk ? 1 : 0);
    chk({tag, " ready mid"}, rdy_mid == !walk, rdy_mid, !walk);
    if (walk) chk({tag, " read address"}, last_ra == exp_ra, last_ra, exp_ra);
    if (exp_st == 2'b00) chk({tag, " page"}, rsp_page == exp_pg, rsp_page, exp_pg);
  endtask

  // {addr, status, walk}
  localparam logic [34:0] VECS [10] = '{
    {32'hE0005000, 2'b00, 1'b1},  // R1 R5 walk through slot 0
    {32'hE0005000, 2'b00, 1'b0},  // R6 cache hit
    {32'hE0407000, 2'b01, 1'b1},  // R5 entry bit 0 clear
    {32'hE0800000, 2'b01, 1'b0},  // R2 slot never loaded
    {32'hE0C00000, 2'b01, 1'b0},  // R2 slot invalidated
    {32'hE2000000, 2'b10, 1'b0},  // R4 index 8 with 8 slots
    {32'hDFFFF000, 2'b10, 1'b0},  // R3 below base wraps out of range
    {32'hE17FF000, 2'b00, 1'b1},  // R1 last entry of a table
    {32'hE0407000, 2'b01, 1'b1},  // R9 fault not cached
    {32'hE1C01000, 2'b00, 1'b1}   // R4 last enabled slot
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) exp_dir[i] = '0;
    repeat (3) @(negedge clk);
    chk("R11 ready in reset", req_ready == 1'b1, req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rsp_valid idle", rsp_valid == 1'b0, rsp_valid, 0);
    chk("R11 mem_rd_valid idle", mem_rd_valid == 1'b0, mem_rd_valid, 0);
    // R11 default: base 0, 64 slots, all absent
    run("R11 absent slot", 32'h0F000000, 2'b01, 1'b0, 1'b0, '0);

    cfg(2'b01, 32'hE03FFFFF);       // R3 low bits ignored
    cfg(2'b10, 32'd56);
    cfg(2'b11, 32'h00002280);
    dir_load(0, 20'h00100, 1'b1);
    dir_load(1, 20'h00200, 1'b1);
    dir_load(3, 20'h00400, 1'b1);
    dir_load(3, 20'h00000, 1'b0);   // R2 invalidate
    dir_load(5, 20'h00500, 1'b1);
    dir_load(7, 20'h00700, 1'b1);

    for (int v = 0; v < 10; v++)
      run($sformatf("vector %0d", v), VECS[v][34:3], VECS[v][2:1], VECS[v][0], 1'b0, '0);

    // R4 size encodings
    cfg(2'b10, 32'd0);
    run("R4 size 0 index 8", 32'hE2000000, 2'b01, 1'b0, 1'b0, '0);
    cfg(2'b10, 32'd32);
    run("R4 size 32 index 31", 32'hE7C00000, 2'b01, 1'b0, 1'b0, '0);
    run("R4 size 32 index 32", 32'hE8000000, 2'b10, 1'b0, 1'b0, '0);
    cfg(2'b10, 32'd48);
    run("R4 size 48 index 15", 32'hE3C00000, 2'b01, 1'b0, 1'b0, '0);
    run("R4 size 48 index 16", 32'hE4000000, 2'b10, 1'b0, 1'b0, '0);
    cfg(2'b10, 32'd56);

    // R8 flush only on rising bit 7
    begin
      logic [19:0] old_pg;
      old_pg = mem_word({20'h00100, 10'd5, 2'b00}) >> 12;
      dir_load(0, 20'h00300, 1'b1);
      cfg(2'b11, 32'h00002280);
      run("R8 bit 7 held high keeps cache", 32'hE0005000, 2'b00, 1'b0, 1'b1, old_pg);
      cfg(2'b11, 32'h00002200);
      run("R8 bit 7 cleared keeps cache", 32'hE0005000, 2'b00, 1'b0, 1'b1, old_pg);
      cfg(2'b11, 32'h00002280);
      run("R8 rising bit 7 flushes", 32'hE0005000, 2'b00, 1'b1, 1'b0, '0);
    end

    // R7 round-robin eviction
    for (int k = 1; k <= 5; k++)
      run($sformatf("R7 fill %0d", k), 32'hE1400000 + k * 32'h1000, 2'b00, 1'b1, 1'b0, '0);
    run("R7 recent entry hits", 32'hE1404000, 2'b00, 1'b0, 1'b0, '0);
    run("R7 oldest entry evicted", 32'hE1401000, 2'b00, 1'b1, 1'b0, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule